// File: doc/BRIEF.md
# Jump Next-PC Unit with Delay Slot

This block holds the fetch address of a 32-bit word-addressed processor front end and works out the next fetch address for jump instructions. It sees the instruction fetched at the current address, a register value read for the instruction's source-register field, and an advance enable. From these it produces the next address and a request to write a return address into the register file.

Four jumps are recognised. Two of them take an absolute target from a 26-bit field in the instruction: a plain jump, and a jump that also links. The other two take their target from a register value: a plain register jump, and a register jump that also links. Every jump has one delay slot. The instruction that follows the jump is always fetched and executed. Control moves to the target only on the advance after that one. While the delay slot is being fetched, the unit does not treat that instruction as a jump.

The register file, conditional branches and exceptions are outside this block. The register value is supplied by the surrounding pipeline.

Top module: `jnpc_top`

## Requirements
- R1: On reset, `pc` loads `RESET_VEC` (default 32'hBFC0_0000) and `slot_pend` is 0.
- R2: While `adv` is 0, `pc` and `slot_pend` hold their values and `link_we` is 0.
- R3: An instruction that is not a jump moves `pc` to `pc+4` on an advance and raises no link write. Every instruction with opcode `instr[31:26]`=0 counts as not a jump, except those with function field `instr[5:0]`=6'h08 or 6'h09. An instruction whose low six bits are 6'h08 but whose opcode is nonzero is also not a jump.
- R4: Opcodes 6'b000010 (plain jump) and 6'b000011 (linking jump) are absolute jumps. On an advance, `pc` becomes `pc+4` and `slot_pend` becomes 1. On the next advance, `pc` becomes {bits [31:28] of (jump address + 4), `instr[25:0]`, 2'b00}.
- R5: Opcode 0 with function 6'h08 is a register jump. Its target is `rs_val` with bits [1:0] forced to 0. The timing is the same as in R4.
- R6: A linking jump raises `link_we` in the cycle it is decoded with `adv`=1. It drives `link_reg`=31 and `link_addr`=`pc+8`.
- R7: Opcode 0 with function 6'h09 is a linking register jump. It raises `link_we` with `link_reg`=`instr[15:11]` and `link_addr`=`pc+8`, and takes its target as in R5.
- R8: While `slot_pend` is 1, the fetched instruction is never treated as a jump and raises no link write. On an advance, `pc` loads the held target and `slot_pend` clears.
- R9: `next_pc` always equals the value that `pc` takes on the next advance.
- R10: `pc` bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| adv | input | 1 | Advance enable. When 0, all state holds. |
| instr | input | 32 | Instruction fetched at `pc` |
| rs_val | input | 32 | Register value read for the instruction's source field |
| pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Address that `pc` takes on the next advance |
| link_we | output | 1 | Request to write the return address |
| link_reg | output | 5 | Register to be written with the return address |
| link_addr | output | 32 | Return address (`pc+8`) |
| slot_pend | output | 1 | The instruction at `pc` is a delay slot |

## Verification
The assertions assume that `instr` and `rs_val` are stable and valid around each rising clock edge. They also assume that `adv` is a clean level, with no other condition attached to it. They do not need the instruction stream to be a legal program. For example, a jump sitting in a delay slot is allowed and must simply be ignored.

The stimulus changes its inputs only at falling edges. It draws mostly from the four jump encodings, from opcode-0 words with other function codes, and from fully random words. It drops `adv` about a quarter of the time, so that stalls land both on jumps and on delay slots.

// File: rtl/jnpc_pkg.sv
package jnpc_pkg;
  localparam int AW = 32;
  localparam int OPW = 6;
  localparam logic [OPW-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OPW-1:0] OP_JABS    = 6'b000010;
  localparam logic [OPW-1:0] OP_JABSL   = 6'b000011;
  localparam logic [OPW-1:0] FN_JREG    = 6'h08;
  localparam logic [OPW-1:0] FN_JREGL   = 6'h09;
  localparam logic [4:0]     LINK_RA    = 5'd31;

  typedef enum logic [2:0] {
    JK_NONE  = 3'd0,
    JK_ABS   = 3'd1,
    JK_ABSL  = 3'd2,
    JK_REG   = 3'd3,
    JK_REGL  = 3'd4
  } jkind_e;

  function automatic logic [AW-1:0] pc_step(input logic [AW-1:0] p, input int unsigned words);
    return p + AW'(words * 4);
  endfunction

  function automatic logic [AW-1:0] abs_target(input logic [AW-1:0] p, input logic [25:0] idx);
    logic [AW-1:0] seq;
    seq = pc_step(p, 1);
    return {seq[AW-1:28], idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] reg_target(input logic [AW-1:0] v);
    return {v[AW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/jnpc_decode.sv
module jnpc_decode
  import jnpc_pkg::*;
(
  input  logic [31:0] instr,
  output jkind_e      kind,
  output logic        is_jump,
  output logic        is_link,
  output logic [4:0]  link_dst
);
  logic [OPW-1:0] opc;
  logic [OPW-1:0] fnc;
  logic hit_abs, hit_absl, hit_reg, hit_regl;

  assign opc = instr[31:26];
  assign fnc = instr[5:0];

  assign hit_abs  = (opc == OP_JABS);
  assign hit_absl = (opc == OP_JABSL);
  assign hit_reg  = (opc == OP_SPECIAL) && (fnc == FN_JREG);
  assign hit_regl = (opc == OP_SPECIAL) && (fnc == FN_JREGL);

  always_comb begin
    kind = JK_NONE;
    if (hit_abs)       kind = JK_ABS;
    else if (hit_absl) kind = JK_ABSL;
    else if (hit_reg)  kind = JK_REG;
    else if (hit_regl) kind = JK_REGL;
  end

  assign is_jump  = (kind != JK_NONE);
  assign is_link  = (kind == JK_ABSL) || (kind == JK_REGL);
  assign link_dst = (kind == JK_REGL) ? instr[15:11] : LINK_RA;

  // R3
  always_comb begin
    decode_onehot_chk: assert ($onehot0({hit_abs, hit_absl, hit_reg, hit_regl}));
  end
endmodule

// File: rtl/jnpc_target.sv
module jnpc_target
  import jnpc_pkg::*;
(
  input  logic [AW-1:0] pc,
  input  logic [31:0]   instr,
  input  logic [AW-1:0] rs_val,
  input  jkind_e        kind,
  output logic [AW-1:0] target,
  output logic [AW-1:0] ret_addr
);
  always_comb begin
    case (kind)
      JK_ABS, JK_ABSL: target = abs_target(pc, instr[25:0]);
      JK_REG, JK_REGL: target = reg_target(rs_val);
      default:         target = pc_step(pc, 1);
    endcase
  end

  assign ret_addr = pc_step(pc, 2);

  // R10
  always_comb begin
    target_align_chk: assert (target[1:0] == 2'b00);
  end
endmodule

// File: rtl/jnpc_seq.sv
module jnpc_seq
  import jnpc_pkg::*;
#(
  parameter logic [AW-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          take_jump,
  input  logic [AW-1:0] jump_tgt,
  output logic [AW-1:0] pc,
  output logic          pend,
  output logic [AW-1:0] next_pc
);
  logic [AW-1:0] held_q;
  logic          load_held;
  logic          arm_slot;

  assign load_held = adv && pend;
  assign arm_slot  = adv && !pend && take_jump;
  assign next_pc   = pend ? held_q : pc_step(pc, 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= RESET_VEC;
      pend   <= 1'b0;
      held_q <= '0;
    end else if (adv) begin
      pc   <= next_pc;
      pend <= arm_slot;
      if (arm_slot) held_q <= jump_tgt;
    end
  end

  // R2
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc) && $stable(pend));
  // R4
  slot_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_slot |=> pend && (pc == $past(pc) + 32'd4));
  // R8
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_held |=> !pend && (pc == $past(held_q)));
endmodule

// File: rtl/jnpc_top.sv
module jnpc_top
  import jnpc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_reg,
  output logic [31:0] link_addr,
  output logic        slot_pend
);
  jkind_e      kind;
  logic        dec_jump;
  logic        dec_link;
  logic [4:0]  dec_dst;
  logic [31:0] tgt;
  logic [31:0] ret;
  logic        jump_live;

  jnpc_decode u_dec (
    .instr    (instr),
    .kind     (kind),
    .is_jump  (dec_jump),
    .is_link  (dec_link),
    .link_dst (dec_dst)
  );

  jnpc_target u_tgt (
    .pc       (pc),
    .instr    (instr),
    .rs_val   (rs_val),
    .kind     (kind),
    .target   (tgt),
    .ret_addr (ret)
  );

  // A decoded jump counts only outside a delay slot.
  assign jump_live = dec_jump && !slot_pend;

  jnpc_seq #(.RESET_VEC(RESET_VEC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .take_jump (jump_live),
    .jump_tgt  (tgt),
    .pc        (pc),
    .pend      (slot_pend),
    .next_pc   (next_pc)
  );

  assign link_we   = adv && jump_live && dec_link;
  assign link_reg  = dec_dst;
  assign link_addr = ret;

  // R6
  link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> adv && !slot_pend);
  // R10
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
  // R9
  next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> pc == $past(next_pc));
  // R8
  slot_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pend |-> !link_we);
endmodule

// File: tb/jnpc_top_test.sv
module jnpc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] pc, next_pc, link_addr;
  logic        link_we, slot_pend;
  logic [4:0]  link_reg;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc;
  logic        m_pend;
  logic [31:0] m_tgt;

  localparam logic [31:0] RV = 32'hBFC0_0000;

  always #2.5 clk = ~clk;

  jnpc_top uut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .instr(instr), .rs_val(rs_val),
    .pc(pc), .next_pc(next_pc), .link_we(link_we), .link_reg(link_reg),
    .link_addr(link_addr), .slot_pend(slot_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 abs, 2 abs+link, 3 reg, 4 reg+link
  function automatic int kind_of(input logic [31:0] w);
    if (w[31:26] == 6'd2) return 1;
    if (w[31:26] == 6'd3) return 2;
    if (w[31:26] == 6'd0 && w[5:0] == 6'd8) return 3;
    if (w[31:26] == 6'd0 && w[5:0] == 6'd9) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] want_tgt(input logic [31:0] p, input logic [31:0] w,
                                           input logic [31:0] r);
    int k;
    logic [31:0] s;
    k = kind_of(w);
    s = p + 32'd4;
    if (k == 1 || k == 2) return (s & 32'hF000_0000) | ({6'd0, w[25:0]} << 2);
    return r & ~32'd3;
  endfunction

  task automatic step(input logic a, input logic [31:0] w, input logic [31:0] r);
    int k;
    logic lw;
    @(negedge clk);
    chk("R10 pc aligned", {30'd0, pc[1:0]}, 32'd0);
    chk("R4/R5/R8 pc", pc, m_pc);
    chk("R8 slot_pend", {31'd0, slot_pend}, {31'd0, m_pend});
    adv = a; instr = w; rs_val = r;
    #1;
    k = kind_of(w);
    lw = a && !m_pend && (k == 2 || k == 4);
    chk("R2/R6/R7 link_we", {31'd0, link_we}, {31'd0, lw});
    if (lw) begin
      chk("R6/R7 link_reg", {27'd0, link_reg}, {27'd0, (k == 2) ? 5'd31 : w[15:11]});
      chk("R6/R7 link_addr", link_addr, m_pc + 32'd8);
    end
    chk("R9 next_pc", next_pc, m_pend ? m_tgt : m_pc + 32'd4);
    if (a) begin
      if (m_pend) begin
        m_pc = m_tgt; m_pend = 1'b0;
      end else if (k != 0) begin
        m_tgt = want_tgt(m_pc, w, r); m_pc = m_pc + 32'd4; m_pend = 1'b1;
      end else begin
        m_pc = m_pc + 32'd4;
      end
    end
  endtask

  function automatic logic [31:0] rand_instr();
    int sel;
    logic [31:0] w;
    sel = int'($urandom % 8);
    w = $urandom;
    case (sel)
      0: w[31:26] = 6'd2;
      1: w[31:26] = 6'd3;
      2: begin w[31:26] = 6'd0; w[5:0] = 6'h08; end
      3: begin w[31:26] = 6'd0; w[5:0] = 6'h09; end
      4: begin w[31:26] = 6'd0; if (w[5:1] == 5'b00100) w[5:0] = 6'h20; end
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    m_pc = RV; m_pend = 1'b0; m_tgt = '0;
    repeat (3) @(posedge clk);
    // R1 reset state
    @(negedge clk);
    chk("R1 reset pc", pc, RV);
    chk("R1 reset slot_pend", {31'd0, slot_pend}, 32'd0);
    rst_n = 1'b1;
    // R3 non-jump opcode 0 and nonzero opcode with low bits 0x08
    step(1'b1, 32'h0000_0020, 32'h0);
    step(1'b1, 32'h8C00_0008, 32'h0);
    // R2 stall on an absolute linking jump: no link, pc holds
    step(1'b0, 32'h0C00_1234, 32'h0);
    // R4/R6 linking absolute jump, then a jump in the delay slot (R8)
    step(1'b1, 32'h0C00_1234, 32'h0);
    step(1'b0, 32'h0000_F809, 32'h1111_1110);
    step(1'b1, 32'h0000_F809, 32'h1111_1110);
    // R5 register jump with misaligned value
    step(1'b1, 32'h03E0_0008, 32'h8000_4003);
    step(1'b1, 32'h0000_0000, 32'h0);
    // R7 linking register jump to rd=7
    step(1'b1, 32'h0060_3809, 32'h0040_0100);
    step(1'b1, 32'h0000_0000, 32'h0);
    // R4 plain absolute jump with max index
    step(1'b1, 32'h0BFF_FFFF, 32'h0);
    step(1'b1, 32'h0000_0000, 32'h0);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, rand_instr(), $urandom);
    end
    step(1'b0, 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule